// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block sits between two asynchronous interrupt pins and the interrupt controller of a chip. It brings each pin into the clock domain with a flop chain. It then turns the pin into an event for the controller under a trigger condition chosen per pin. The choices are low level, high level, falling edge, rising edge and any edge. Pin 0 feeds the controller's highest-priority source (vector 0x20) and pin 1 feeds vector 0x24. The controller keeps the pending and mask state, so this block only produces events.

One 32-bit register on the controller's register bus, at offset 0x04, holds both 3-bit trigger selectors next to the synchronized level of each pin. In any-edge mode, software reads the level bit after the event to learn the direction: a 0 means the pin fell and a 1 means it rose.

Each pin has a small history machine with three states. ST_ARM means the history is not valid. ST_LO means the last synchronized level was low, and ST_HI means it was high. On reset or on any write to the register, a pin enters ST_ARM (transition "rearm"). From any state with no write pending, the next state is ST_HI if the synchronized level is 1 and ST_LO if it is 0 (transitions "track high" and "track low"). An ST_LO to ST_HI step is a rise and an ST_HI to ST_LO step is a fall. Leaving ST_ARM is never an edge.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset both selectors read 010 (falling edge), both level bits read 0 with the pins low, and both event outputs are 0.
- R2: The register answers only at bus offset 0x04. Reads at any other offset return 0, and writes to other offsets change nothing.
- R3: Register layout: bits 2:0 are the pin 0 selector, bit 3 is the pin 0 level, bits 6:4 are the pin 1 selector, bit 7 is the pin 1 level, and bits 31:8 read 0. Writes to bits 3, 7 and 31:8 have no effect.
- R4: A level bit shows the pin value two clock edges after the pin changes.
- R5: Selector 000 (low level) drives the pin's event output high whenever the synchronized level is 0, one edge after the level bit.
- R6: Selector 001 (high level) drives the event output high whenever the synchronized level is 1, one edge after the level bit.
- R7: Selector 010 (falling edge) gives a one-cycle pulse on the event output, visible three edges after the pin falls.
- R8: Selector 011 (rising edge) gives a one-cycle pulse three edges after the pin rises. A falling pin gives no pulse.
- R9: Selectors 1xx (any edge) pulse on both directions. After the pulse, the level bit reads 0 for a fall and 1 for a rise.
- R10: A register write reloads every pin's history from its current level. When the pin is steady, a change of selector never causes an edge pulse.
- R11: The two pins act independently; an event or level on one never shows on the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register bus offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| pin_in | input | 2 | Asynchronous interrupt pins |
| irq_out | output | 2 | Event per pin to the interrupt controller (bit 0 to vector 0x20, bit 1 to vector 0x24) |

## Verification
The assertions check four things on every cycle. Each level bit must lag its pin by two edges. A level mode must follow the previous level bit. A rising-edge output must never stay high for two cycles in a row. A register write must silence the edge modes in the cycle that follows it. Other behaviour only the bench's scenarios can show. This includes the register layout and the offset decode, the ignored read-only bits, and the three-edge pulse timing for each selector value. It also covers any-edge direction read through the level bit, and the absence of any pulse when a selector changes under a steady pin.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int MODE_W  = 3;
    localparam int FIELD_W = 4;
    localparam logic [MODE_W-1:0] MODE_RESET = 3'b010;

    typedef enum logic [2:0] {
        TRIG_LOW,
        TRIG_HIGH,
        TRIG_FALL,
        TRIG_RISE,
        TRIG_ANY
    } trig_e;

    typedef enum logic [1:0] {
        ST_ARM,
        ST_LO,
        ST_HI
    } hist_e;

    function automatic trig_e decode_mode(input logic [MODE_W-1:0] m);
        trig_e t;
        if (m[2]) begin
            t = TRIG_ANY;
        end else begin
            case (m[1:0])
                2'b00:   t = TRIG_LOW;
                2'b01:   t = TRIG_HIGH;
                2'b10:   t = TRIG_FALL;
                default: t = TRIG_RISE;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [MODE_W-1:0] mode,
    input  logic              rearm,
    output logic              irq
);
    hist_e state_q, state_d;
    trig_e trig;
    logic  rise, fall, hit, irq_q;

    assign trig = decode_mode(mode);

    always_comb begin
        if (rearm) begin
            state_d = ST_ARM;
        end else if (lvl) begin
            state_d = ST_HI;
        end else begin
            state_d = ST_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            ST_LO:   rise = lvl;
            ST_HI:   fall = !lvl;
            default: ;
        endcase
    end

    always_comb begin
        unique case (trig)
            TRIG_LOW:  hit = !lvl;
            TRIG_HIGH: hit = lvl;
            TRIG_FALL: hit = fall;
            TRIG_RISE: hit = rise;
            default:   hit = rise | fall;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int                NUM_PINS   = 2,
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h04
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [NUM_PINS-1:0]        lvl,
    output logic [NUM_PINS*MODE_W-1:0] mode_flat,
    output logic                       rearm,
    output logic [DATA_W-1:0]          bus_rdata
);
    logic [NUM_PINS-1:0][MODE_W-1:0] mode_q;
    logic sel, wr_hit;
    logic unused_wdata;

    assign sel          = (bus_addr == REG_OFFSET);
    assign wr_hit       = bus_wr && sel;
    assign rearm        = wr_hit;
    assign unused_wdata = ^bus_wdata;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_mode
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q[i] <= MODE_RESET;
            end else if (wr_hit) begin
                mode_q[i] <= bus_wdata[i*FIELD_W +: MODE_W];
            end
        end
        assign mode_flat[i*MODE_W +: MODE_W] = mode_q[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (sel) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                bus_rdata[i*FIELD_W +: MODE_W]  = mode_q[i];
                bus_rdata[i*FIELD_W + MODE_W]   = lvl[i];
            end
        end
    end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int                NUM_PINS    = 2,
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] REG_OFFSET  = 8'h04
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] irq_out
);
    localparam int MODE_BITS = NUM_PINS * MODE_W;

    logic [NUM_PINS-1:0]  sync_lvl;
    logic [MODE_BITS-1:0] mode_flat;
    logic                 rearm;

    ext_irq_regs #(
        .NUM_PINS  (NUM_PINS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_OFFSET(REG_OFFSET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .lvl      (sync_lvl),
        .mode_flat(mode_flat),
        .rearm    (rearm),
        .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pin_in[i]),
            .q    (sync_lvl[i])
        );

        ext_irq_chan u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (sync_lvl[i]),
            .mode (mode_flat[i*MODE_W +: MODE_W]),
            .rearm(rearm),
            .irq  (irq_out[i])
        );
    end
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
    parameter int                NUM_PINS    = 2,
    parameter int                ADDR_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] REG_OFFSET  = 8'h04
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic [NUM_PINS-1:0]   pin_in,
    input logic [NUM_PINS-1:0]   irq_out,
    input logic [NUM_PINS-1:0]   lvl,
    input logic [NUM_PINS*3-1:0] mode_flat
);
    logic [1:0] since_rst;
    logic       wr_hit;

    assign wr_hit = bus_wr && (bus_addr == REG_OFFSET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        if (SYNC_STAGES == 2) begin : g_two
            // R4
            lvl_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= 2'd2) |-> (lvl[i] == $past(pin_in[i], 2)));
        end

        // R5
        low_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd1 && $past(mode_flat[i*3 +: 3]) == 3'b000)
            |-> (irq_out[i] == !$past(lvl[i])));

        // R6
        high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd1 && $past(mode_flat[i*3 +: 3]) == 3'b001)
            |-> (irq_out[i] == $past(lvl[i])));

        // R8
        rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2 && irq_out[i]
             && $past(mode_flat[i*3 +: 3]) == 3'b011
             && $past(mode_flat[i*3 +: 3], 2) == 3'b011)
            |-> !$past(irq_out[i]));

        // R10
        rearm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2 && $past(wr_hit, 2)
             && ($past(mode_flat[i*3 + 2]) || $past(mode_flat[i*3 + 1])))
            |-> !irq_out[i]);
    end
endmodule

bind ext_irq_detect ext_irq_detect_chk #(
    .NUM_PINS   (NUM_PINS),
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .pin_in   (pin_in),
    .irq_out  (irq_out),
    .lvl      (sync_lvl),
    .mode_flat(mode_flat)
);

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pin_in = 2'b00;
    logic [1:0]  irq_out;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [1:0] v;
        string      tag;
    } exp_t;
    exp_t sb[$];

    ext_irq_detect dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .irq_out  (irq_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=%0d cycles expected<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        for (int j = sb.size() - 1; j >= 0; j--) begin
            if (sb[j].at == cyc) begin
                checks++;
                if (irq_out !== sb[j].v) begin
                    errors++;
                    $display("FAIL %s cyc=%0d irq actual=%b expected=%b",
                             sb[j].tag, cyc, irq_out, sb[j].v);
                end
                sb.delete(j);
            end
        end
    end

    task automatic expect_at(input int off, input logic [1:0] v, input string tag);
        exp_t e;
        e.at  = cyc + off;
        e.v   = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        tick(3);
        rst_n = 1'b1;
        tick(3);

        rd(8'h04, r);
        chk("R1 reset register", r, 32'h0000_0022);
        chk("R1 reset irq", {30'd0, irq_out}, 32'd0);

        rd(8'h08, r);
        chk("R2 other offset reads zero", r, 32'd0);
        wr(8'h08, 32'h0000_0055);
        rd(8'h04, r);
        chk("R2 write elsewhere ignored", r, 32'h0000_0022);

        wr(8'h04, 32'hFFFF_FF88);
        rd(8'h04, r);
        chk("R3 read-only bits ignored", r, 32'h0000_0000);

        // low level on both pins, pins low
        expect_at(2, 2'b11, "R5 low level");
        tick(3);
        pin_in[0] = 1'b1;
        expect_at(2, 2'b11, "R5 before level change");
        expect_at(3, 2'b10, "R5 R11 pin0 high clears only irq0");
        tick(4);

        wr(8'h04, 32'h0000_0001);
        expect_at(2, 2'b11, "R6 high level pin0, low level pin1");
        tick(3);

        pin_in[1] = 1'b1;
        tick(1);
        rd(8'h04, r);
        chk("R4 level bit one edge after change", {31'd0, r[7]}, 32'd0);
        tick(1);
        rd(8'h04, r);
        chk("R4 level bit two edges after change", {31'd0, r[7]}, 32'd1);
        expect_at(1, 2'b01, "R5 pin1 high drops irq1");
        tick(3);

        // falling edge mode under steady high pins
        wr(8'h04, 32'h0000_0022);
        expect_at(1, 2'b00, "R10 no pulse after write");
        expect_at(2, 2'b00, "R10 no pulse after write");
        expect_at(3, 2'b00, "R10 no pulse after write");
        tick(4);
        pin_in[0] = 1'b0;
        expect_at(2, 2'b00, "R7 not yet");
        expect_at(3, 2'b01, "R7 fall pulse");
        expect_at(4, 2'b00, "R7 one cycle");
        tick(5);

        wr(8'h04, 32'h0000_0033);
        expect_at(1, 2'b00, "R10 no pulse after write");
        expect_at(3, 2'b00, "R10 no pulse after write");
        tick(4);
        pin_in = 2'b01;
        expect_at(3, 2'b01, "R8 rise pulse pin0 only");
        expect_at(4, 2'b00, "R8 one cycle");
        tick(5);

        wr(8'h04, 32'h0000_0044);
        tick(3);
        pin_in[0] = 1'b0;
        expect_at(3, 2'b01, "R9 any edge fall");
        expect_at(4, 2'b00, "R9 one cycle");
        tick(3);
        rd(8'h04, r);
        chk("R9 direction fall", {31'd0, r[3]}, 32'd0);
        tick(2);
        pin_in[0] = 1'b1;
        expect_at(3, 2'b01, "R9 any edge rise");
        expect_at(4, 2'b00, "R9 one cycle");
        tick(3);
        rd(8'h04, r);
        chk("R9 direction rise", {31'd0, r[3]}, 32'd1);
        tick(2);

        wr(8'h04, 32'h0000_0077);
        rd(8'h04, r);
        chk("R3 layout with pin0 high", r, 32'h0000_007F);
        tick(3);
        pin_in[1] = 1'b1;
        expect_at(3, 2'b10, "R9 R11 selector 111 rise on pin1");
        expect_at(4, 2'b00, "R9 one cycle");
        tick(6);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard leftover actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule